// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides, for a bridge between a host-side (primary) bus and a device-side (secondary) bus, whether an I/O or memory access should cross the bridge. It holds an I/O window, a non-prefetchable memory window and a prefetchable memory window that can sit anywhere in a 64-bit space. Two optional modifiers apply on top of these windows. The first carves legacy ISA aliases out of the I/O window. The second claims the fixed VGA frame buffer.

Each query presents a space (I/O or memory), the side the access came from, and a 64-bit address. For single-address cycles the upper word is zero. One cycle later the block returns registered verdicts: forward downstream, forward upstream, and whether a downstream memory access is prefetchable. Queries arrive as a valid-qualified stream with no ready signal. The block accepts a query in every cycle and never stalls, so it applies no back-pressure. A simple write port loads the window and control registers.

Top module: `bwin_decoder`

## Requirements
- R1: After reset every window is disabled and all control bits are zero. The I/O register resets to 0x000000F0, the memory and prefetchable registers to 0x0000FFF0, the prefetchable upper-base to 0xFFFFFFFF and the prefetchable upper-limit to 0. All outputs are low.
- R2: `d_valid` is high in the cycle after each cycle with `q_valid` high, and low otherwise. `fwd_down`, `fwd_up` and `pref` are low whenever `d_valid` is low.
- R3: The I/O window covers {base,000h} to {limit,FFFh} inclusive, on 16-bit I/O addresses. The base is taken from register 0 bits [7:4] and the limit from bits [15:12]. An I/O address with any of bits [63:16] set never hits the window.
- R4: The memory window covers {base,00000h} to {limit,FFFFFh} inclusive. The base is address bits [31:20], held in register 1 bits [15:4]. The limit is held in register 1 bits [31:20]. An address with any of bits [63:32] set misses this window.
- R5: The prefetchable window uses register 2 in the same layout as R4 for address bits [31:20]. Register 3 supplies address bits [63:32] of the base and register 4 supplies them for the limit, so the window spans 64 bits.
- R6: A window whose full base address exceeds its full limit address matches nothing.
- R7: Control register 5 bit 0 enables I/O and bit 1 enables memory. A primary-side access is forwarded downstream only when the enable for its space is set.
- R8: With control bit 2 (ISA) set, an I/O address inside the window with bits [9:8] nonzero is not claimed. These are the upper 768 bytes of each 1 KB block. Only offsets 000h–0FFh of each block are forwarded.
- R9: With control bit 3 (VGA) set, memory addresses 000A0000h–000BFFFFh are claimed. Subject to the memory enable, they are forwarded downstream with `pref` low.
- R10: A primary-side access never raises `fwd_up`. A secondary-side access never raises `fwd_down`. It raises `fwd_up` exactly when no window or VGA range claims it, whatever the enable bits are.
- R11: `pref` is high only with `fwd_down`. It is high when the address is inside the prefetchable window and inside neither the memory window nor the VGA range.
- R12: A write with `wr_sel` 0–5 loads the addressed register. Any other `wr_sel` value changes nothing. A query in the same cycle as a write is decided on the old register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register index |
| wr_data | input | 32 | Register write data |
| q_valid | input | 1 | Query present this cycle |
| q_from_sec | input | 1 | 1: access seen on secondary side, 0: primary |
| q_is_mem | input | 1 | 1: memory space, 0: I/O space |
| q_addr | input | 64 | Access address |
| d_valid | output | 1 | Verdict valid |
| fwd_down | output | 1 | Forward primary to secondary |
| fwd_up | output | 1 | Forward secondary to primary |
| pref | output | 1 | Downstream memory access is prefetchable |

## Verification
A register write and a query can land in the same cycle. The bench provokes this by moving the I/O base off an address while querying that address in the same cycle. The verdict must still forward, which shows the old window was used. The next query to the same address must then not forward. A second overlap exercises the memory window and the prefetchable window claiming the same address. In that case `pref` must drop while `fwd_down` stays high.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  localparam int REG_W  = 32;
  localparam int SEL_W  = 3;
  localparam int NREG   = 6;
  localparam int ADDR_W = 64;
  localparam int NWIN   = 3;

  localparam logic [SEL_W-1:0] SEL_IO   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MEM  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_PREF = 3'd2;
  localparam logic [SEL_W-1:0] SEL_PBHI = 3'd3;
  localparam logic [SEL_W-1:0] SEL_PLHI = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd5;

  typedef enum int { WIN_IO = 0, WIN_MEM = 1, WIN_PF = 2 } win_idx_e;

  typedef struct packed {
    logic [3:0]  io_base;
    logic [3:0]  io_lim;
    logic [11:0] mem_base;
    logic [11:0] mem_lim;
    logic [11:0] pf_base;
    logic [11:0] pf_lim;
    logic [31:0] pf_base_hi;
    logic [31:0] pf_lim_hi;
    logic        io_en;
    logic        mem_en;
    logic        isa_en;
    logic        vga_en;
  } win_cfg_t;

  function automatic logic [REG_W-1:0] reg_reset(input int idx);
    case (idx)
      0:       return 32'h0000_00F0;
      1, 2:    return 32'h0000_FFF0;
      3:       return 32'hFFFF_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/bwin_regs.sv
module bwin_regs
  import bwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output win_cfg_t         cfg
);
  logic [REG_W-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank[g] <= reg_reset(g);
      else if (wr_en && wr_sel == SEL_W'(g))
        bank[g] <= wr_data;
    end
  end

  always_comb begin
    cfg.io_base    = bank[SEL_IO][7:4];
    cfg.io_lim     = bank[SEL_IO][15:12];
    cfg.mem_base   = bank[SEL_MEM][15:4];
    cfg.mem_lim    = bank[SEL_MEM][31:20];
    cfg.pf_base    = bank[SEL_PREF][15:4];
    cfg.pf_lim     = bank[SEL_PREF][31:20];
    cfg.pf_base_hi = bank[SEL_PBHI];
    cfg.pf_lim_hi  = bank[SEL_PLHI];
    cfg.io_en      = bank[SEL_CTRL][0];
    cfg.mem_en     = bank[SEL_CTRL][1];
    cfg.isa_en     = bank[SEL_CTRL][2];
    cfg.vga_en     = bank[SEL_CTRL][3];
  end

  assert_ctrl_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTRL) |=>
      ({cfg.vga_en, cfg.isa_en, cfg.mem_en, cfg.io_en} == $past(wr_data[3:0])));

  assert_bad_sel_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel >= SEL_W'(NREG)) |=> $stable(cfg));
endmodule

// File: rtl/bwin_cmp.sv
module bwin_cmp #(
  parameter int W = 64
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] base,
  input  logic [W-1:0] lim,
  output logic         hit
);
  logic live;
  assign live = (base <= lim);
  assign hit  = live && (addr >= base) && (addr <= lim);
endmodule

// File: rtl/bwin_decoder.sv
module bwin_decoder
  import bwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        q_valid,
  input  logic        q_from_sec,
  input  logic        q_is_mem,
  input  logic [63:0] q_addr,
  output logic        d_valid,
  output logic        fwd_down,
  output logic        fwd_up,
  output logic        pref
);
  localparam int IO_GRAN  = 12;
  localparam int MEM_GRAN = 20;
  localparam int IO_TOP   = 16;
  localparam logic [ADDR_W-18:0] VGA_TAG = (ADDR_W-17)'(5);

  win_cfg_t          cfg;
  logic [ADDR_W-1:0] wbase [NWIN];
  logic [ADDR_W-1:0] wlim  [NWIN];
  logic [NWIN-1:0]   whit;
  logic vga_hit, isa_cut, io_claim, mem_claim, claim, space_on;
  logic nxt_down, nxt_up, nxt_pref;

  bwin_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cfg(cfg)
  );

  always_comb begin
    wbase[WIN_IO]  = {{(ADDR_W-IO_TOP){1'b0}}, cfg.io_base, {IO_GRAN{1'b0}}};
    wlim[WIN_IO]   = {{(ADDR_W-IO_TOP){1'b0}}, cfg.io_lim,  {IO_GRAN{1'b1}}};
    wbase[WIN_MEM] = {32'h0, cfg.mem_base, {MEM_GRAN{1'b0}}};
    wlim[WIN_MEM]  = {32'h0, cfg.mem_lim,  {MEM_GRAN{1'b1}}};
    wbase[WIN_PF]  = {cfg.pf_base_hi, cfg.pf_base, {MEM_GRAN{1'b0}}};
    wlim[WIN_PF]   = {cfg.pf_lim_hi,  cfg.pf_lim,  {MEM_GRAN{1'b1}}};
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    bwin_cmp #(.W(ADDR_W)) u_cmp (
      .addr(q_addr), .base(wbase[g]), .lim(wlim[g]), .hit(whit[g])
    );
  end

  always_comb begin
    vga_hit   = cfg.vga_en && (q_addr[ADDR_W-1:17] == VGA_TAG);
    isa_cut   = cfg.isa_en && (q_addr[9:8] != 2'b00);
    io_claim  = whit[WIN_IO] && !isa_cut;
    mem_claim = whit[WIN_MEM] || whit[WIN_PF] || vga_hit;
    claim     = q_is_mem ? mem_claim : io_claim;
    space_on  = q_is_mem ? cfg.mem_en : cfg.io_en;
    nxt_down  = !q_from_sec && claim && space_on;
    nxt_up    = q_from_sec && !claim;
    nxt_pref  = nxt_down && q_is_mem && whit[WIN_PF] && !whit[WIN_MEM] && !vga_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_valid  <= 1'b0;
      fwd_down <= 1'b0;
      fwd_up   <= 1'b0;
      pref     <= 1'b0;
    end else begin
      d_valid  <= q_valid;
      fwd_down <= q_valid && nxt_down;
      fwd_up   <= q_valid && nxt_up;
      pref     <= q_valid && nxt_pref;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> d_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> (!d_valid && !fwd_down && !fwd_up && !pref));

  assert_one_direction_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fwd_down, fwd_up}) <= 1);

  assert_sec_never_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_from_sec) |=> !fwd_down);

  assert_io_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_is_mem && !cfg.io_en) |=> !fwd_down);

  assert_pref_needs_down_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pref |-> fwd_down);
endmodule

// File: tb/bwin_decoder_test.sv
module bwin_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic        q_valid, q_from_sec, q_is_mem;
  logic [63:0] q_addr;
  logic        d_valid, fwd_down, fwd_up, pref;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bwin_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .q_valid(q_valid), .q_from_sec(q_from_sec), .q_is_mem(q_is_mem), .q_addr(q_addr),
    .d_valid(d_valid), .fwd_down(fwd_down), .fwd_up(fwd_up), .pref(pref)
  );

  typedef struct packed {
    logic        sec;
    logic        mem;
    logic [63:0] a;
    logic [2:0]  exp;   // {fwd_down, fwd_up, pref}
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 64'h0000_0000_0000_2000, 3'b100},
    '{1'b0, 1'b0, 64'h0000_0000_0000_3FFF, 3'b100},
    '{1'b0, 1'b0, 64'h0000_0000_0000_4000, 3'b000},
    '{1'b0, 1'b0, 64'h0000_0000_0000_1FFF, 3'b000},
    '{1'b1, 1'b0, 64'h0000_0000_0000_5000, 3'b010},
    '{1'b1, 1'b0, 64'h0000_0000_0000_2100, 3'b000},
    '{1'b0, 1'b1, 64'h0000_0000_1000_0000, 3'b100},
    '{1'b0, 1'b1, 64'h0000_0000_1FFF_FFFF, 3'b100},
    '{1'b0, 1'b1, 64'h0000_0000_2000_0000, 3'b000},
    '{1'b0, 1'b1, 64'h0000_0001_2000_0000, 3'b101},
    '{1'b0, 1'b1, 64'h0000_0001_2FFF_FFFF, 3'b101},
    '{1'b0, 1'b1, 64'h0000_0001_3000_0000, 3'b000},
    '{1'b0, 1'b1, 64'h0000_0000_2000_0000, 3'b000},
    '{1'b1, 1'b1, 64'h0000_0001_2000_0100, 3'b000},
    '{1'b1, 1'b1, 64'h0000_0000_4000_0000, 3'b010},
    '{1'b0, 1'b1, 64'h0000_0000_000A_0000, 3'b000},
    '{1'b1, 1'b1, 64'h0000_0000_000A_0000, 3'b010}
  };

  task automatic check(input string tag, input logic [2:0] exp);
    n_run++;
    if (d_valid !== 1'b1 || {fwd_down, fwd_up, pref} !== exp) begin
      n_fail++;
      $display("FAIL %s: got valid=%b {down,up,pref}=%b expected valid=1 %b",
               tag, d_valid, {fwd_down, fwd_up, pref}, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic query(input logic sec, input logic mem, input logic [63:0] a);
    @(negedge clk);
    q_valid = 1'b1; q_from_sec = sec; q_is_mem = mem; q_addr = a;
    @(negedge clk);
    q_valid = 1'b0;
  endtask

  task automatic qcheck(input string tag, input logic sec, input logic mem,
                        input logic [63:0] a, input logic [2:0] exp);
    query(sec, mem, a);
    check(tag, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    q_valid = 1'b0; q_from_sec = 1'b0; q_is_mem = 1'b0; q_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state of the outputs
    n_run++;
    if ({d_valid, fwd_down, fwd_up, pref} !== 4'b0000) begin
      n_fail++;
      $display("FAIL R1: got outputs %b expected 0000", {d_valid, fwd_down, fwd_up, pref});
    end
    // R1 windows disabled: secondary accesses go upstream, primary go nowhere
    qcheck("R1 sec io 0",   1'b1, 1'b0, 64'h0, 3'b010);
    qcheck("R1 sec mem 0",  1'b1, 1'b1, 64'h0, 3'b010);
    qcheck("R1 pri mem 0",  1'b0, 1'b1, 64'h0, 3'b000);
    // R2 idle cycle after a query: no verdict
    @(negedge clk);
    n_run++;
    if ({d_valid, fwd_down, fwd_up, pref} !== 4'b0000) begin
      n_fail++;
      $display("FAIL R2: got idle outputs %b expected 0000", {d_valid, fwd_down, fwd_up, pref});
    end

    // Windows: I/O 2000-3FFF, mem 10000000-1FFFFFFF, pref 1_20000000-1_2FFFFFFF
    wreg(3'd0, 32'h0000_3020);
    wreg(3'd1, 32'h1FF0_1000);
    wreg(3'd2, 32'h2FF0_2000);
    wreg(3'd3, 32'h0000_0001);
    wreg(3'd4, 32'h0000_0001);
    // R7 enables still off: inside window, no forwarding, not upstream either
    qcheck("R7 io off",     1'b0, 1'b0, 64'h2000, 3'b000);
    qcheck("R7 mem off",    1'b0, 1'b1, 64'h1000_0000, 3'b000);
    qcheck("R10 sec inside", 1'b1, 1'b0, 64'h2000, 3'b000);
    wreg(3'd5, 32'h0000_0003);

    // R3 R4 R5 R10 R11 vector table
    for (int i = 0; i < NV; i++) begin
      query(VECS[i].sec, VECS[i].mem, VECS[i].a);
      check($sformatf("R3/R4/R5/R10/R11 vector %0d", i), VECS[i].exp);
    end
    qcheck("R3 io upper bits", 1'b0, 1'b0, 64'h0001_0000_0000_2000, 3'b000);

    // R8 ISA aliasing
    wreg(3'd5, 32'h0000_0007);
    qcheck("R8 isa low 2000",  1'b0, 1'b0, 64'h2000, 3'b100);
    qcheck("R8 isa low 20FF",  1'b0, 1'b0, 64'h20FF, 3'b100);
    qcheck("R8 isa hi 2100",   1'b0, 1'b0, 64'h2100, 3'b000);
    qcheck("R8 isa hi 23FF",   1'b0, 1'b0, 64'h23FF, 3'b000);
    qcheck("R8 isa next 2400", 1'b0, 1'b0, 64'h2400, 3'b100);
    qcheck("R8 isa sec 2100",  1'b1, 1'b0, 64'h2100, 3'b010);

    // R9 VGA range
    wreg(3'd5, 32'h0000_000B);
    qcheck("R9 vga A0000",  1'b0, 1'b1, 64'h000A_0000, 3'b100);
    qcheck("R9 vga BFFFF",  1'b0, 1'b1, 64'h000B_FFFF, 3'b100);
    qcheck("R9 vga C0000",  1'b0, 1'b1, 64'h000C_0000, 3'b000);
    qcheck("R9 vga 9FFFF",  1'b0, 1'b1, 64'h0009_FFFF, 3'b000);
    qcheck("R9 vga sec",    1'b1, 1'b1, 64'h000A_0000, 3'b000);

    // R12 unsupported index ignored
    wreg(3'd6, 32'h0000_0000);
    wreg(3'd7, 32'h0000_0000);
    qcheck("R12 bad sel",   1'b0, 1'b1, 64'h1000_0000, 3'b100);

    // R12 write and query in the same cycle: old I/O base used
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h0000_3030;
    q_valid = 1'b1; q_from_sec = 1'b0; q_is_mem = 1'b0; q_addr = 64'h2000;
    @(negedge clk);
    wr_en = 1'b0; q_valid = 1'b0;
    check("R12 same cycle old", 3'b100);
    qcheck("R12 after write",  1'b0, 1'b0, 64'h2000, 3'b000);

    // R6 memory base above limit
    wreg(3'd1, 32'h1000_3000);
    qcheck("R6 mem disabled",  1'b0, 1'b1, 64'h1000_0000, 3'b000);
    qcheck("R6 mem sec up",    1'b1, 1'b1, 64'h1000_0000, 3'b010);
    // R6 prefetchable upper base above upper limit
    wreg(3'd3, 32'h0000_0002);
    qcheck("R6 pref hi disabled", 1'b0, 1'b1, 64'h0000_0001_2000_0000, 3'b000);

    // R11 overlap of memory and prefetchable windows: not prefetchable
    wreg(3'd1, 32'h1FF0_1000);
    wreg(3'd2, 32'h1FF0_1000);
    wreg(3'd3, 32'h0000_0000);
    wreg(3'd4, 32'h0000_0000);
    qcheck("R11 overlap",     1'b0, 1'b1, 64'h1800_0000, 3'b100);
    wreg(3'd1, 32'h0000_FFF0);
    qcheck("R11 pref only",   1'b0, 1'b1, 64'h1800_0000, 3'b101);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule